// File: doc/BRIEF.md
# Interrupt Source Gateway

This block turns a parameterised set of interrupt wires, numbered 1 to `NUM_SRC`, into a vector of deliverable requests. Each source has a 3-bit mode field. The mode picks how the source's synchronised wire becomes a pending bit: the wire can be ignored, or its rising edge, falling edge, high level or low level can be sampled. Each source also has an enable bit. Software sets or clears an enable by writing the source's number to one of two number registers. It can also raise pending on a detached or edge-mode source by writing the number to a set-pending register. A bit in the domain configuration register gates every output at once.

Each source holds a two-state machine, `ST_IDLE` and `ST_PEND`. The *raise* transition (`ST_IDLE` to `ST_PEND`) is taken in three cases: on the selected edge, on a set-pending write, or while a level source is active and not being claimed. The *drop* transition (`ST_PEND` to `ST_IDLE`) is taken in three cases: on a claim that is not met by a new event in the same cycle, when a level source goes inactive, or when the mode becomes inactive. A downstream arbiter reads `irq_out`, picks a source and presents its number on the claim port. The register port is a single-cycle write with a combinational read.

Top module: `irq_gateway`

## Requirements
- R1: After reset, `irq_out` is all zero, and the domain configuration register (offset 0x0000) and every source configuration register read as zero.
- R2: Bit 8 of the domain configuration register is the domain enable. While it is clear, `irq_out` is all zero. Setting it again exposes pending-and-enabled sources with no loss of pending state. It reads back in bit 8.
- R3: In mode 4 (rising edge), pending is raised on a 0-to-1 change of the synchronised wire. It stays raised after the wire falls, and it is cleared by a claim of that source number.
- R4: In mode 5 (falling edge), pending is raised on a 1-to-0 change of the wire. A 0-to-1 change does not raise it.
- R5: In mode 6 (level high), pending follows the wire. A claim while the wire is still high leaves the source pending again a cycle later.
- R6: In mode 7 (level low), pending is the inverse of the wire.
- R7: In mode 1 (detached), the wire has no effect. Writing the source number to the set-pending register (0x1CDC) raises pending, and a claim clears it.
- R8: Writing number s to 0x1EDC enables source s. Writing it to 0x1FDC disables it. A source reaches `irq_out` only while it is enabled, and disabling it keeps its pending state.
- R9: Mode values 0, 2 and 3 hold a source's pending and enable bits at zero. While a source is in one of these modes, enable and set-pending writes to it are ignored.
- R10: A write of 0 or of a number greater than `NUM_SRC` to a set-enable, clear-enable or set-pending register changes no source.
- R11: When a set-pending write and a claim of the same source fall in the same cycle, the source stays pending.
- R12: The configuration of source s is at byte offset 4·s, with its mode in bits [2:0]. Reads of the number registers return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Raw source wires; bit s is source s |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| claim_valid | input | 1 | Claim strobe |
| claim_id | input | ID_W | Number of the source being claimed |
| irq_out | output | NUM_SRC | Pending and enabled and domain-enabled, bit s is source s |

## Verification
A claim and a new pending event can hit the same source in one cycle, and that collision decides whether an interrupt is lost. The bench provokes it by driving a set-pending write of a detached, enabled source together with a claim of that source on a single clock edge. It judges the result by `irq_out` still showing the source a few cycles later, and then by a lone claim clearing it. The level-high case is also covered: a claim against a wire that is still active must show the source pending again after the claim.

// File: rtl/srcgw_pkg.sv
package srcgw_pkg;

    typedef enum logic [2:0] {
        SM_OFF    = 3'd0,
        SM_DETACH = 3'd1,
        SM_RSV2   = 3'd2,
        SM_RSV3   = 3'd3,
        SM_RISE   = 3'd4,
        SM_FALL   = 3'd5,
        SM_HIGH   = 3'd6,
        SM_LOW    = 3'd7
    } src_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } pend_state_e;

    localparam int unsigned OFF_DOMCFG = 32'h0000;
    localparam int unsigned OFF_SETIP  = 32'h1CDC;
    localparam int unsigned OFF_SETIE  = 32'h1EDC;
    localparam int unsigned OFF_CLRIE  = 32'h1FDC;
    localparam int unsigned DOM_IE_BIT = 8;

    function automatic logic mode_live(src_mode_e m);
        return (m == SM_DETACH) || (m == SM_RISE) || (m == SM_FALL) ||
               (m == SM_HIGH)   || (m == SM_LOW);
    endfunction

endpackage

// File: rtl/srcgw_sync.sv
module srcgw_sync #(
    parameter int WIDTH  = 31,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= '0;
        end else begin
            chain[0] <= d_in;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
        end
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/srcgw_cell.sv
module srcgw_cell
    import srcgw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wire_s,
    input  logic       cfg_we,
    input  logic [2:0] cfg_wdata,
    input  logic       setie_hit,
    input  logic       clrie_hit,
    input  logic       setip_hit,
    input  logic       claim_hit,
    output logic [2:0] cfg_q,
    output logic       pend_o,
    output logic       en_o
);
    logic [2:0]  cfg_r;
    src_mode_e   mode;
    logic        live, is_edge, is_level, wire_d, lvl_act, edge_evt, set_evt;
    pend_state_e state_q, state_d;
    logic        en_q;

    assign mode = src_mode_e'(cfg_r);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_r  <= '0;
            wire_d <= 1'b0;
        end else begin
            wire_d <= wire_s;
            if (cfg_we) cfg_r <= cfg_wdata;
        end
    end

    always_comb begin
        live     = mode_live(mode);
        is_edge  = (mode == SM_RISE) || (mode == SM_FALL);
        is_level = (mode == SM_HIGH) || (mode == SM_LOW);
        lvl_act  = (mode == SM_HIGH) ? wire_s : !wire_s;
        edge_evt = ((mode == SM_RISE) && wire_s && !wire_d) ||
                   ((mode == SM_FALL) && !wire_s && wire_d);
        set_evt  = edge_evt || (setip_hit && (is_edge || (mode == SM_DETACH)));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: raise / drop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (is_level) begin
                    if (lvl_act && !claim_hit) state_d = ST_PEND;
                end else if (live && set_evt) begin
                    state_d = ST_PEND;
                end
            end
            ST_PEND: begin
                if (!live) begin
                    state_d = ST_IDLE;
                end else if (is_level) begin
                    if (claim_hit || !lvl_act) state_d = ST_IDLE;
                end else if (claim_hit && !set_evt) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         en_q <= 1'b0;
        else if (!live)     en_q <= 1'b0;
        else if (setie_hit) en_q <= 1'b1;
        else if (clrie_hit) en_q <= 1'b0;
    end

    // outputs
    always_comb begin
        cfg_q  = cfg_r;
        pend_o = (state_q == ST_PEND);
        en_o   = en_q;
    end

    // R3
    edge_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt |=> (state_q == ST_PEND));

    // R5
    level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_level && lvl_act && !claim_hit) |=> (state_q == ST_PEND));

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!live && $past(!live)) |-> (state_q == ST_IDLE && !en_q));

    // R8
    enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setie_hit && live && !cfg_we) |=> en_q);

    // R11
    set_beats_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setip_hit && claim_hit && !is_level && live) |=> (state_q == ST_PEND));
endmodule

// File: rtl/irq_gateway.sv
module irq_gateway
    import srcgw_pkg::*;
#(
    parameter int NUM_SRC     = 31,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int ID_W        = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC:1]   irq_in,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               claim_valid,
    input  logic [ID_W-1:0]    claim_id,
    output logic [NUM_SRC:1]   irq_out
);
    localparam logic [ADDR_W-1:0] A_DOM   = ADDR_W'(OFF_DOMCFG);
    localparam logic [ADDR_W-1:0] A_SETIP = ADDR_W'(OFF_SETIP);
    localparam logic [ADDR_W-1:0] A_SETIE = ADDR_W'(OFF_SETIE);
    localparam logic [ADDR_W-1:0] A_CLRIE = ADDR_W'(OFF_CLRIE);

    logic [NUM_SRC:1] wire_s, pend_vec, en_vec;
    logic [2:0]       cfg_arr [1:NUM_SRC];
    logic             dom_ie_q;
    logic             wr_setip, wr_setie, wr_clrie;

    srcgw_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (irq_in),
        .q_out (wire_s)
    );

    always_comb begin
        wr_setip = reg_we && (reg_addr == A_SETIP);
        wr_setie = reg_we && (reg_addr == A_SETIE);
        wr_clrie = reg_we && (reg_addr == A_CLRIE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           dom_ie_q <= 1'b0;
        else if (reg_we && reg_addr == A_DOM) dom_ie_q <= reg_wdata[DOM_IE_BIT];
    end

    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
        logic num_hit;
        assign num_hit = (reg_wdata == DATA_W'(s));
        srcgw_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .wire_s    (wire_s[s]),
            .cfg_we    (reg_we && (reg_addr == ADDR_W'(4 * s))),
            .cfg_wdata (reg_wdata[2:0]),
            .setie_hit (wr_setie && num_hit),
            .clrie_hit (wr_clrie && num_hit),
            .setip_hit (wr_setip && num_hit),
            .claim_hit (claim_valid && (claim_id == ID_W'(s))),
            .cfg_q     (cfg_arr[s]),
            .pend_o    (pend_vec[s]),
            .en_o      (en_vec[s])
        );
    end

    assign irq_out = pend_vec & en_vec & {NUM_SRC{dom_ie_q}};

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_DOM) reg_rdata[DOM_IE_BIT] = dom_ie_q;
        for (int s = 1; s <= NUM_SRC; s++) begin
            if (reg_addr == ADDR_W'(4 * s)) reg_rdata[2:0] = cfg_arr[s];
        end
    end

    // R2
    dom_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_DOM && !reg_wdata[DOM_IE_BIT]) |=> (irq_out == '0));

    // R10
    bad_number_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_setie || wr_clrie) && (reg_wdata == '0 || reg_wdata > DATA_W'(NUM_SRC)))
        |=> $stable(en_vec));
endmodule

// File: tb/test_irq_gateway.sv
module test_irq_gateway;
    localparam int N = 31;
    localparam logic [1:0] OP_WR = 2'd0, OP_WIRE = 2'd1, OP_CLM = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  req;
        logic [15:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 37;
    localparam vec_t TABLE [NVEC] = '{
        '{OP_WR,   4'd2,  16'h0000, 32'h100, 32'h0},  // R2 domain on
        '{OP_WR,   4'd12, 16'h0004, 32'h4,   32'h0},  // R12 src1 rising
        '{OP_WR,   4'd8,  16'h1EDC, 32'd1,   32'h0},  // R8
        '{OP_WIRE, 4'd3,  16'h0,    32'h2,   32'h2},  // R3 rise
        '{OP_WIRE, 4'd3,  16'h0,    32'h0,   32'h2},  // R3 held
        '{OP_CLM,  4'd3,  16'h0,    32'd1,   32'h0},  // R3 claim
        '{OP_WR,   4'd4,  16'h0008, 32'h5,   32'h0},  // R4 src2 falling
        '{OP_WR,   4'd8,  16'h1EDC, 32'd2,   32'h0},
        '{OP_WIRE, 4'd4,  16'h0,    32'h4,   32'h0},  // R4 rise ignored
        '{OP_WIRE, 4'd4,  16'h0,    32'h0,   32'h4},  // R4 fall
        '{OP_CLM,  4'd4,  16'h0,    32'd2,   32'h0},
        '{OP_WR,   4'd5,  16'h000C, 32'h6,   32'h0},  // R5 src3 high
        '{OP_WR,   4'd8,  16'h1EDC, 32'd3,   32'h0},
        '{OP_WIRE, 4'd5,  16'h0,    32'h8,   32'h8},  // R5 follows
        '{OP_CLM,  4'd5,  16'h0,    32'd3,   32'h8},  // R5 re-raise
        '{OP_WIRE, 4'd5,  16'h0,    32'h0,   32'h0},
        '{OP_WR,   4'd6,  16'h000C, 32'h7,   32'h8},  // R6 low level
        '{OP_WIRE, 4'd6,  16'h0,    32'h8,   32'h0},  // R6
        '{OP_WR,   4'd7,  16'h0010, 32'h1,   32'h0},  // R7 src4 detached
        '{OP_WR,   4'd8,  16'h1EDC, 32'd4,   32'h0},
        '{OP_WIRE, 4'd7,  16'h0,    32'h18,  32'h0},  // R7 wire ignored
        '{OP_WR,   4'd7,  16'h1CDC, 32'd4,   32'h10}, // R7 set pending
        '{OP_WR,   4'd2,  16'h0000, 32'h0,   32'h0},  // R2 off
        '{OP_WR,   4'd2,  16'h0000, 32'h100, 32'h10}, // R2 on again
        '{OP_WR,   4'd8,  16'h1FDC, 32'd4,   32'h0},  // R8 clear
        '{OP_WR,   4'd8,  16'h1EDC, 32'd4,   32'h10}, // R8 pending kept
        '{OP_CLM,  4'd7,  16'h0,    32'd4,   32'h0},  // R7 claim
        '{OP_WR,   4'd9,  16'h0014, 32'h2,   32'h0},  // R9 src5 reserved
        '{OP_WR,   4'd9,  16'h1EDC, 32'd5,   32'h0},
        '{OP_WR,   4'd9,  16'h1CDC, 32'd5,   32'h0},
        '{OP_WR,   4'd9,  16'h0014, 32'h1,   32'h0},  // R9 nothing kept
        '{OP_WR,   4'd7,  16'h1CDC, 32'd5,   32'h0},
        '{OP_WR,   4'd8,  16'h1EDC, 32'd5,   32'h20},
        '{OP_WR,   4'd10, 16'h1FDC, 32'd0,   32'h20}, // R10 zero
        '{OP_WR,   4'd10, 16'h1FDC, 32'd37,  32'h20}, // R10 above N
        '{OP_WR,   4'd10, 16'h1CDC, 32'd36,  32'h20}, // R10 above N
        '{OP_CLM,  4'd7,  16'h0,    32'd5,   32'h0}
    };

    logic           clk = 1'b0, rst_n = 1'b0;
    logic [N:1]     irq_in = '0;
    logic           reg_we = 1'b0;
    logic [15:0]    reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           claim_valid = 1'b0;
    logic [9:0]     claim_id = '0;
    logic [N:1]     irq_out;
    int             n_chk = 0, n_fail = 0;
    bit             done = 1'b0;

    always #2 clk = ~clk;

    irq_gateway i_irq_gateway (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .claim_valid(claim_valid), .claim_id(claim_id), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        case (v.op)
            OP_WR:   begin reg_we = 1'b1; reg_addr = v.addr; reg_wdata = v.data; end
            OP_WIRE: irq_in = v.data[N:1];
            default: begin claim_valid = 1'b1; claim_id = v.data[9:0]; end
        endcase
        @(negedge clk);
        reg_we = 1'b0; claim_valid = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic read_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq_out", {irq_out, 1'b0}, 32'h0);
        read_chk("R1 domain cfg", 16'h0000, 32'h0);
        read_chk("R1 source cfg", 16'h0004, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            apply(TABLE[i]);
            check($sformatf("R%0d row %0d", TABLE[i].req, i), {irq_out, 1'b0}, TABLE[i].exp);
        end

        // R11: set-pending and claim of source 4 in one cycle
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 16'h1CDC; reg_wdata = 32'd4;
        claim_valid = 1'b1; claim_id = 10'd4;
        @(negedge clk);
        reg_we = 1'b0; claim_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 set wins", {irq_out, 1'b0}, 32'h10);
        apply('{OP_CLM, 4'd11, 16'h0, 32'd4, 32'h0});
        check("R11 lone claim", {irq_out, 1'b0}, 32'h0);

        // R12 readback
        read_chk("R12 src3 mode", 16'h000C, 32'h7);
        read_chk("R12 src4 mode", 16'h0010, 32'h1);
        read_chk("R12 number reg", 16'h1EDC, 32'h0);
        read_chk("R2 domain bit", 16'h0000, 32'h100);
        finish_run();
    end
endmodule